// File: doc/BRIEF.md
# Descriptor Queue and Writeback Processor

This block sits on one direction (host-to-device or device-to-host) of a DMA engine driven by an external descriptor controller. Descriptors arrive from host memory as 256-bit words. The block decodes each word into source address, destination address, byte length, index tag and writeback enable, and holds the decoded words in a 16-entry queue. It then hands them one at a time to the data mover as commands, using a valid/ready handshake.

For each command it hands out, the block records the tag and the writeback enable in an in-flight tracker, oldest first. When the data mover reports a completion with an index, the block loads the queue's completed pointer from that index. It compares the index with the oldest in-flight tag and sets a sticky error flag if they differ. When the oldest in-flight descriptor asked for writeback, the block issues a writeback command: the host address comes from a per-queue writeback base, and the data is the 16-bit completed pointer. The writeback command goes out on the device-to-host command path for either direction.

The interrupt enable bit and the reserved bits of a descriptor are accepted and ignored.

Top module: `desc_wb_proc`

## Requirements
- R1: A mover command carries the descriptor's source address (bits 63:0) on `mv_src`, its destination address (bits 127:64) on `mv_dst`, and its index (bits 175:160) on `mv_tag`. Commands leave in the order their descriptors were accepted.
- R2: `mv_len` is 21 bits wide. It equals the 20-bit payload count in bits 147:128, except that a count of zero gives 0x100000 (1 MB).
- R3: The descriptor queue holds 16 entries. `desc_ready` is low while it is full, and a descriptor offered in that state is not taken.
- R4: While `mv_valid` is high and `mv_ready` is low, `mv_valid` stays high and the command fields stay unchanged.
- R5: One cycle after a status pulse (`st_valid` high), `cmpl_ptr` equals the `st_index` of that pulse.
- R6: A status pulse raises `wb_valid` in the next cycle only if the oldest in-flight descriptor had its writeback enable bit (bit 177) set. The command then carries `wb_addr` = `wb_base` and `wb_data` = the status index.
- R7: The interrupt enable bit (bit 176) and the reserved bits (255:178 and 159:148) have no effect on any output.
- R8: `idx_err` goes high one cycle after a status whose index differs from the oldest in-flight tag, or after a status that arrives with nothing in flight. It then stays high until reset.
- R9: `wb_valid` stays high until `wb_ready` accepts it. A writeback-enabled status that arrives while a writeback is still waiting replaces the waiting data with the newer pointer.
- R10: After reset, `desc_ready` = 1, `mv_valid` = 0, `wb_valid` = 0, `cmpl_ptr` = 0 and `idx_err` = 0.
- R11: At most 16 commands are in flight. While 16 are unacknowledged, `mv_valid` stays low even if the queue holds a descriptor, and it rises again after a status retires one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor word valid |
| desc_ready | output | 1 | Descriptor queue can accept |
| desc_data | input | 256 | Raw host descriptor |
| mv_valid | output | 1 | Mover command valid |
| mv_ready | input | 1 | Mover accepts command |
| mv_src | output | 64 | Source address |
| mv_dst | output | 64 | Destination address |
| mv_len | output | 21 | Transfer length in bytes |
| mv_tag | output | 16 | Descriptor index tag |
| st_valid | input | 1 | Completion status pulse |
| st_index | input | 16 | Index of completed descriptor |
| wb_base | input | 64 | Per-queue writeback host address |
| wb_valid | output | 1 | Writeback command valid |
| wb_ready | input | 1 | Writeback command accepted |
| wb_addr | output | 64 | Writeback host address |
| wb_data | output | 16 | Completed pointer written back |
| cmpl_ptr | output | 16 | Queue completed pointer |
| idx_err | output | 1 | Sticky status-order error |

## Verification
A wrong descriptor queue pointer or count shows up in the first mover command after it. That command carries a wrong or repeated tag, or `desc_ready` stays high past 16 entries. A wrong in-flight tracker state shows up one cycle after the next status pulse. It appears as a spurious or missing `wb_valid`, or as `idx_err` rising on a correctly ordered completion. A corrupted writeback holding register shows up in `wb_data` or `wb_addr` before `wb_ready` accepts it.

// File: rtl/dqwb_pkg.sv
// Shared descriptor field positions and the decoded command type.
// Assumes a fixed 256-bit host descriptor word.
package dqwb_pkg;
    localparam int DESC_W  = 256;
    localparam int ADDR_W  = 64;
    localparam int PAY_W   = 20;
    localparam int LEN_W   = PAY_W + 1;
    localparam int TAG_W   = 16;
    localparam int SRC_LO  = 0;
    localparam int DST_LO  = 64;
    localparam int PAY_LO  = 128;
    localparam int TAG_LO  = 160;
    localparam int IRQ_BIT = 176;
    localparam int WB_BIT  = 177;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << PAY_W;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
        logic              wb_en;
    } mv_cmd_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             wb_en;
    } flight_t;
endpackage

// File: rtl/dqwb_fifo.sv
// Synchronous FIFO with a combinational head read.
// Assumes the writer never pushes when full and the reader never pops when empty.
module dqwb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;

    assign full    = (count == CNT_MAX);
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3 / R11: the owner never writes into a full queue
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R11: the owner never pops an empty queue
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/dqwb_desc_decode.sv
// Turns a raw 256-bit host descriptor into a mover command.
// Assumes a purely combinational path. The interrupt and reserved bits are dropped here.
module dqwb_desc_decode
    import dqwb_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output mv_cmd_t           cmd
);
    logic [PAY_W-1:0] pay;
    logic             unused_bits;

    assign pay         = raw[PAY_LO +: PAY_W];
    assign unused_bits = ^{raw[DESC_W-1:WB_BIT+1], raw[IRQ_BIT],
                           raw[TAG_LO-1:PAY_LO+PAY_W]};

    // Pick out the fields and widen a zero payload count to the full 1 MB length.
    always_comb begin
        cmd.src   = raw[SRC_LO +: ADDR_W];
        cmd.dst   = raw[DST_LO +: ADDR_W];
        cmd.len   = (pay == '0) ? MAX_LEN : {1'b0, pay};
        cmd.tag   = raw[TAG_LO +: TAG_W];
        cmd.wb_en = raw[WB_BIT];
    end
endmodule

// File: rtl/dqwb_cmpl_track.sv
// Completion side: retires in-flight entries on status, loads the completed
// pointer, flags out-of-order indices and holds one writeback command.
// Assumes one status pulse per cycle at most and no backpressure on status.
module dqwb_cmpl_track
    import dqwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_index,
    input  logic              head_valid,
    input  flight_t           head,
    input  logic [ADDR_W-1:0] wb_base,
    input  logic              wb_ready,
    output logic              pop,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [TAG_W-1:0]  wb_data,
    output logic [TAG_W-1:0]  cmpl_ptr,
    output logic              idx_err
);
    logic wb_load;

    assign pop     = st_valid && head_valid;
    assign wb_load = pop && head.wb_en;

    // Follow each status index with the completed pointer and latch order errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_ptr <= '0;
            idx_err  <= 1'b0;
        end else if (st_valid) begin
            cmpl_ptr <= st_index;
            if (!head_valid || head.tag != st_index) idx_err <= 1'b1;
        end
    end

    // Hold the writeback command, letting a newer completion replace a stalled one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else if (wb_load) begin
            wb_valid <= 1'b1;
            wb_addr  <= wb_base;
            wb_data  <= st_index;
        end else if (wb_ready) begin
            wb_valid <= 1'b0;
        end
    end

    // R5: completed pointer follows the status index one cycle later
    a_r5_cmpl_follow: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> cmpl_ptr == $past(st_index));
    // R8: the error flag never clears outside reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err);
    // R9: a waiting writeback is not dropped
    a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid);
    // R6: a writeback appears only after an enabled completion
    a_r6_wb_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(st_valid && head_valid && head.wb_en));
endmodule

// File: rtl/desc_wb_proc.sv
// Top level: descriptor queue -> mover command, in-flight tracker -> writeback.
// Assumes the mover reports completions in the order the commands were issued.
module desc_wb_proc
    import dqwb_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int FDEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DESC_W-1:0] desc_data,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic [ADDR_W-1:0] mv_src,
    output logic [ADDR_W-1:0] mv_dst,
    output logic [LEN_W-1:0]  mv_len,
    output logic [TAG_W-1:0]  mv_tag,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_index,
    input  logic [ADDR_W-1:0] wb_base,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [TAG_W-1:0]  wb_data,
    output logic [TAG_W-1:0]  cmpl_ptr,
    output logic              idx_err
);
    localparam int CMD_W = $bits(mv_cmd_t);
    localparam int FLT_W = $bits(flight_t);

    mv_cmd_t dec_cmd, head_cmd;
    flight_t flt_in, flt_head;
    logic    q_full, q_empty, f_full, f_empty;
    logic    desc_fire, mv_fire, f_pop;

    assign desc_ready = !q_full;
    assign desc_fire  = desc_valid && desc_ready;
    assign mv_valid   = !q_empty && !f_full;
    assign mv_fire    = mv_valid && mv_ready;
    assign mv_src     = head_cmd.src;
    assign mv_dst     = head_cmd.dst;
    assign mv_len     = head_cmd.len;
    assign mv_tag     = head_cmd.tag;
    assign flt_in     = '{tag: head_cmd.tag, wb_en: head_cmd.wb_en};

    dqwb_desc_decode i_decode (
        .raw (desc_data),
        .cmd (dec_cmd)
    );

    dqwb_fifo #(.WIDTH(CMD_W), .DEPTH(QDEPTH)) i_desc_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (desc_fire),
        .wr_data (dec_cmd),
        .rd_en   (mv_fire),
        .rd_data (head_cmd),
        .full    (q_full),
        .empty   (q_empty)
    );

    dqwb_fifo #(.WIDTH(FLT_W), .DEPTH(FDEPTH)) i_flight_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mv_fire),
        .wr_data (flt_in),
        .rd_en   (f_pop),
        .rd_data (flt_head),
        .full    (f_full),
        .empty   (f_empty)
    );

    dqwb_cmpl_track i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_index   (st_index),
        .head_valid (!f_empty),
        .head       (flt_head),
        .wb_base    (wb_base),
        .wb_ready   (wb_ready),
        .pop        (f_pop),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .cmpl_ptr   (cmpl_ptr),
        .idx_err    (idx_err)
    );

    // R4: an offered command is held unchanged until taken
    a_r4_mv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && !mv_ready |=> mv_valid && $stable(mv_tag) && $stable(mv_src)
                                  && $stable(mv_dst) && $stable(mv_len));
    // R2: every offered length lies in 1 .. 1 MB
    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> (mv_len != '0) && (mv_len <= MAX_LEN));
    // R11: no command is offered while the tracker is full
    a_r11_flight_cap: assert property (@(posedge clk) disable iff (!rst_n)
        f_full |-> !mv_valid);
endmodule

// File: tb/test_desc_wb_proc.sv
module test_desc_wb_proc;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         desc_valid = 1'b0;
    logic         desc_ready;
    logic [255:0] desc_data = '0;
    logic         mv_valid;
    logic         mv_ready = 1'b0;
    logic [63:0]  mv_src, mv_dst;
    logic [20:0]  mv_len;
    logic [15:0]  mv_tag;
    logic         st_valid = 1'b0;
    logic [15:0]  st_index = '0;
    logic [63:0]  wb_base = 64'hFEED_0000_0000_1000;
    logic         wb_valid;
    logic         wb_ready = 1'b0;
    logic [63:0]  wb_addr;
    logic [15:0]  wb_data;
    logic [15:0]  cmpl_ptr;
    logic         idx_err;
    int           n_chk = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    desc_wb_proc i_desc_wb_proc (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_desc(input logic [63:0] s, input logic [63:0] d,
            input logic [19:0] cnt, input logic [15:0] idx, input bit wb, input bit irq,
            input bit junk);
        logic [255:0] r = '0;
        r[63:0] = s; r[127:64] = d; r[147:128] = cnt; r[175:160] = idx;
        r[176] = irq; r[177] = wb;
        if (junk) begin r[255:178] = '1; r[159:148] = '1; end
        return r;
    endfunction

    task automatic put_desc(input logic [255:0] d);
        @(negedge clk);
        desc_valid = 1'b1; desc_data = d;
        while (!desc_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic take_mv();
        while (!mv_valid) @(negedge clk);
        mv_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mv_ready = 1'b0;
    endtask

    task automatic status(input logic [15:0] idx);
        @(negedge clk);
        st_valid = 1'b1; st_index = idx;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(desc_ready == 1'b1, "R10", "desc_ready", desc_ready, 1);
        chk(mv_valid == 1'b0, "R10", "mv_valid", mv_valid, 0);
        chk(wb_valid == 1'b0, "R10", "wb_valid", wb_valid, 0);
        chk(cmpl_ptr == 16'd0, "R10", "cmpl_ptr", cmpl_ptr, 0);
        chk(idx_err == 1'b0, "R10", "idx_err", idx_err, 0);
    endtask

    task automatic t_decode();
        put_desc(mk_desc(64'h1111_2222_3333_4440, 64'hAAAA_BBBB_CCCC_D000, 20'h00ABC, 16'd1, 1'b1, 1'b0, 1'b0));
        chk(mv_valid, "R1", "mv_valid", mv_valid, 1);
        chk(mv_src == 64'h1111_2222_3333_4440, "R1", "mv_src", mv_src, 64'h1111_2222_3333_4440);
        chk(mv_dst == 64'hAAAA_BBBB_CCCC_D000, "R1", "mv_dst", mv_dst, 64'hAAAA_BBBB_CCCC_D000);
        chk(mv_tag == 16'd1, "R1", "mv_tag", mv_tag, 1);
        chk(mv_len == 21'h00ABC, "R2", "mv_len", mv_len, 21'h00ABC);
        repeat (2) @(negedge clk);
        chk(mv_valid && mv_tag == 16'd1, "R4", "held tag", mv_tag, 1);
        take_mv();
        put_desc(mk_desc(64'h5, 64'h6, 20'h0, 16'd2, 1'b0, 1'b1, 1'b1));
        chk(mv_len == 21'h100000, "R2", "zero count len", mv_len, 21'h100000);
        chk(mv_src == 64'h5 && mv_dst == 64'h6, "R7", "src with junk bits", mv_src, 64'h5);
        chk(mv_tag == 16'd2, "R7", "tag with junk bits", mv_tag, 2);
        take_mv();
        status(16'd1);
        chk(cmpl_ptr == 16'd1, "R5", "cmpl_ptr", cmpl_ptr, 1);
        chk(wb_valid == 1'b1, "R6", "wb_valid", wb_valid, 1);
        chk(wb_addr == wb_base, "R6", "wb_addr", wb_addr, wb_base);
        chk(wb_data == 16'd1, "R6", "wb_data", wb_data, 1);
        wb_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wb_ready = 1'b0;
        chk(wb_valid == 1'b0, "R9", "wb cleared after accept", wb_valid, 0);
        status(16'd2);
        chk(cmpl_ptr == 16'd2, "R5", "cmpl_ptr", cmpl_ptr, 2);
        chk(wb_valid == 1'b0, "R7", "no wb with irq bit only", wb_valid, 0);
        chk(idx_err == 1'b0, "R8", "no error in order", idx_err, 0);
    endtask

    task automatic t_fill();
        bit order_ok = 1'b1;
        logic [15:0] first_bad = '0;
        for (int i = 0; i < 16; i++)
            put_desc(mk_desc(64'(i), 64'(i), 20'h40, 16'(10 + i), 1'b0, 1'b0, 1'b0));
        chk(desc_ready == 1'b0, "R3", "ready low when full", desc_ready, 0);
        @(negedge clk);
        desc_valid = 1'b1; desc_data = mk_desc(64'h0, 64'h0, 20'h1, 16'd99, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (!mv_valid || mv_tag != 16'(10 + i)) begin
                if (order_ok) first_bad = mv_tag;
                order_ok = 1'b0;
            end
            take_mv();
        end
        chk(order_ok, "R1", "queue order", first_bad, 0);
        chk(desc_ready == 1'b1, "R3", "ready after drain", desc_ready, 1);
        put_desc(mk_desc(64'h77, 64'h88, 20'h10, 16'd26, 1'b0, 1'b0, 1'b0));
        chk(mv_valid == 1'b0, "R11", "held while 16 in flight", mv_valid, 0);
        chk(mv_valid == 1'b0, "R3", "17th offered word not taken", mv_tag, 26);
        status(16'd10);
        chk(mv_valid && mv_tag == 16'd26, "R11", "released after retire", mv_tag, 26);
        for (int i = 11; i < 26; i++) status(16'(i));
        take_mv();
        status(16'd26);
        chk(cmpl_ptr == 16'd26 && !idx_err, "R5", "pointer after drain", cmpl_ptr, 26);
        chk(wb_valid == 1'b0, "R6", "no wb without enable", wb_valid, 0);
    endtask

    task automatic t_stall();
        put_desc(mk_desc(64'h1, 64'h2, 20'h8, 16'd30, 1'b1, 1'b0, 1'b0));
        take_mv();
        put_desc(mk_desc(64'h3, 64'h4, 20'h8, 16'd31, 1'b1, 1'b0, 1'b0));
        take_mv();
        status(16'd30);
        repeat (3) @(negedge clk);
        chk(wb_valid && wb_data == 16'd30, "R9", "stalled wb held", wb_data, 30);
        wb_base = 64'hFEED_0000_0000_2000;
        status(16'd31);
        chk(wb_valid && wb_data == 16'd31, "R9", "newer pointer replaces", wb_data, 31);
        chk(wb_addr == 64'hFEED_0000_0000_2000, "R6", "wb_addr from base", wb_addr, 64'hFEED_0000_0000_2000);
        wb_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wb_ready = 1'b0;
        chk(!wb_valid, "R9", "single wb after coalesce", wb_valid, 0);
    endtask

    task automatic t_mismatch();
        put_desc(mk_desc(64'h9, 64'h9, 20'h4, 16'd40, 1'b0, 1'b0, 1'b0));
        take_mv();
        chk(idx_err == 1'b0, "R8", "no error before", idx_err, 0);
        status(16'd41);
        chk(idx_err == 1'b1, "R8", "error on wrong index", idx_err, 1);
        chk(cmpl_ptr == 16'd41, "R5", "pointer still loaded", cmpl_ptr, 41);
        repeat (3) @(negedge clk);
        chk(idx_err == 1'b1, "R8", "error sticky", idx_err, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_fill();
        t_stall();
        t_mismatch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule